// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block turns single-word read and write requests from a synchronous valid/ready port into the strobe sequence of a DRAM with a shared row/column address bus. A request address is split into a row part (upper bits) and a column part (lower bits). The row goes out on the shared address pins when the row strobe falls. The column goes out later, when the column strobe falls. Read data comes back on the request side as a single-cycle response pulse.

After an access the row strobe stays low, so the row remains open as a page. A later request to the same row then costs only a column phase. A request to a different row first raises the row strobe for a precharge time and then opens the new row. An internal timer, set in clock cycles from the clock frequency and a nominal 15.625 us interval, raises a refresh request. The refresh waits for any access in progress, closes the open row, and strobes the next row of a wrapping refresh counter with the row strobe alone.

Top module: `dram_page_ctrl`

## Requirements
- R1: Out of reset both strobes are high (inactive), `req_ready` is high, `rsp_valid` is low, no row is open and the refresh row counter is zero.
- R2: The row is `req_addr[ROW_W+COL_W-1:COL_W]` and the column is `req_addr[COL_W-1:0]`. Both are driven zero-extended on `dram_addr`: the row when `dram_ras_n` falls, the column while `dram_cas_n` is low.
- R3: A read accepted with no row open asserts `rsp_valid` in the T_RCD+T_CL+1-th cycle after the accepting clock edge, carrying the word stored at that address.
- R4: A read to the open row (page hit) causes no row strobe activity, holds `dram_cas_n` low for T_CL cycles, and asserts `rsp_valid` in the T_CL+1-th cycle after acceptance.
- R5: A request to a row other than the open one (page miss) raises `dram_ras_n` for T_RP cycles, opens the new row, and a read then asserts `rsp_valid` in the T_RP+T_RCD+T_CL+1-th cycle after acceptance.
- R6: `dram_we_n` is low in every column cycle of a write (with `dram_wdata` equal to the accepted data) and high in every column cycle of a read, so a written word reads back unchanged.
- R7: Refresh strobes `dram_ras_n` low with no column strobe while `dram_addr` carries the refresh row. The refresh row starts at 0 and steps by one, wrapping at 2^ROW_W. Successive refreshes are REF_CYC cycles apart, within the access-deferral window.
- R8: A refresh never starts while an access is in progress. While a refresh is pending, `req_ready` is low.
- R9: A refresh leaves no row open, so the first access after it follows the timing of R3.
- R10: `dram_ras_n` is high for at least T_RP cycles before each fall. `dram_cas_n` falls only after `dram_ras_n` has been low for at least T_RCD cycles, and `dram_cas_n` is low only while `dram_ras_n` is low.
- R11: `rsp_valid` is a single-cycle pulse, one per accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_wdata | output | DATA_W | Data to the DRAM |
| dram_rdata | input | DATA_W | Data from the DRAM |

## Verification
Directed requests first hit a closed bank, then the same row, then a different row. They then hit a bank just closed by refresh. Each case separates the three latency classes by exact cycle count and checks the stored data. Constrained-random traffic reuses the previous row most of the time, so that hits, misses, writes and reads mix with refreshes falling due mid-access. A behavioural DRAM model tells refresh (row strobe without a column strobe) apart from an access. Against that model the bench checks the refresh row order, the refresh spacing, the strobe minimum timings, and that no refresh starts inside a read.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_CAS,
        ST_RRAS,
        ST_RREC
    } dstate_e;

    typedef enum logic [1:0] {
        AS_ROW,
        AS_COL,
        AS_REF
    } asel_e;
endpackage

// File: rtl/dramc_ref_timer.sv
module dramc_ref_timer #(
    parameter int REF_CYC = 3906,
    parameter int ROW_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_done,
    output logic             ref_pend,
    output logic [ROW_W-1:0] ref_row
);
    localparam int CNT_W = (REF_CYC > 2) ? $clog2(REF_CYC) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic [ROW_W-1:0] row;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == '0) begin
            tmr_d.cnt  = CNT_W'(REF_CYC - 1);
            tmr_d.pend = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
            if (ref_done) tmr_d.pend = 1'b0;
        end
        if (ref_done) tmr_d.row = tmr_q.row + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt  <= CNT_W'(REF_CYC - 1);
            tmr_q.pend <= 1'b0;
            tmr_q.row  <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign ref_pend = tmr_q.pend;
    assign ref_row  = tmr_q.row;

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> ref_row == $past(ref_row) + 1'b1); // R7
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pend && !ref_done) |=> ref_pend); // R8
endmodule

// File: rtl/dramc_page_track.sv
module dramc_page_track #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             open_clr,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             row_open,
    output logic             row_hit
);
    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        if (open_clr) pg_d.open = 1'b0;
        if (open_set) begin
            pg_d.open = 1'b1;
            pg_d.row  = set_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign row_open = pg_q.open;
    assign row_hit  = pg_q.open && (pg_q.row == cmp_row);

    AST_OPEN_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        open_set |=> row_open); // R4
    AST_CLOSED_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (open_clr && !open_set) |=> !row_open); // R9
endmodule

// File: rtl/dramc_addr_mux.sv
module dramc_addr_mux
    import dramc_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int MA_W  = 4
) (
    input  asel_e            sel,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] ref_row,
    output logic [MA_W-1:0]  addr
);
    always_comb begin
        addr = '0;
        unique case (sel)
            AS_COL:  addr[COL_W-1:0] = col;
            AS_REF:  addr[ROW_W-1:0] = ref_row;
            default: addr[ROW_W-1:0] = row;
        endcase
    end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dramc_pkg::*;
#(
    parameter int ROW_W   = 4,
    parameter int COL_W   = 4,
    parameter int DATA_W  = 8,
    parameter int T_RP    = 2,
    parameter int T_RCD   = 2,
    parameter int T_CL    = 2,
    parameter int T_RAS   = 3,
    parameter int CLK_MHZ = 250,
    parameter int REF_NS  = 15625,
    parameter int REF_CYC = CLK_MHZ * REF_NS / 1000,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [MA_W-1:0]   dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);
    localparam int TMAX_A = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int TMAX_B = (T_CL > T_RAS) ? T_CL : T_RAS;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int CW     = $clog2(TMAX + 1);

    typedef struct packed {
        dstate_e           st;
        logic [CW-1:0]     cnt;
        logic              to_ref;
        logic              we;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        asel_e             asel;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              rsp_v;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             ref_pend, ref_done;
    logic [ROW_W-1:0] ref_row;
    logic             open_set, open_clr, row_open, row_hit;
    logic [ROW_W-1:0] set_row;
    logic [ROW_W-1:0] in_row;
    logic [COL_W-1:0] in_col;
    logic             accept;

    assign in_row    = req_addr[ADDR_W-1:COL_W];
    assign in_col    = req_addr[COL_W-1:0];
    assign req_ready = (c_q.st == ST_IDLE) && !ref_pend;
    assign accept    = req_valid && req_ready;

    dramc_ref_timer #(.REF_CYC(REF_CYC), .ROW_W(ROW_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .ref_done(ref_done),
        .ref_pend(ref_pend), .ref_row(ref_row)
    );

    dramc_page_track #(.ROW_W(ROW_W)) u_page (
        .clk(clk), .rst_n(rst_n), .open_set(open_set), .open_clr(open_clr),
        .set_row(set_row), .cmp_row(in_row), .row_open(row_open), .row_hit(row_hit)
    );

    dramc_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_amux (
        .sel(c_q.asel), .row(c_q.row), .col(c_q.col), .ref_row(ref_row),
        .addr(dram_addr)
    );

    always_comb begin
        c_d      = c_q;
        c_d.rsp_v = 1'b0;
        open_set = 1'b0;
        open_clr = 1'b0;
        set_row  = c_q.row;
        ref_done = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    c_d.to_ref = 1'b1;
                    if (row_open) begin
                        c_d.st    = ST_PRE;
                        c_d.ras_n = 1'b1;
                        c_d.cnt   = CW'(T_RP - 1);
                        open_clr  = 1'b1;
                    end else begin
                        c_d.st    = ST_RRAS;
                        c_d.ras_n = 1'b0;
                        c_d.asel  = AS_REF;
                        c_d.cnt   = CW'(T_RAS - 1);
                    end
                end else if (accept) begin
                    c_d.to_ref = 1'b0;
                    c_d.we     = req_we;
                    c_d.row    = in_row;
                    c_d.col    = in_col;
                    c_d.wdata  = req_wdata;
                    if (row_hit) begin
                        c_d.st    = ST_CAS;
                        c_d.cas_n = 1'b0;
                        c_d.we_n  = !req_we;
                        c_d.asel  = AS_COL;
                        c_d.cnt   = CW'(T_CL - 1);
                    end else if (row_open) begin
                        c_d.st    = ST_PRE;
                        c_d.ras_n = 1'b1;
                        c_d.cnt   = CW'(T_RP - 1);
                        open_clr  = 1'b1;
                    end else begin
                        c_d.st    = ST_ACT;
                        c_d.ras_n = 1'b0;
                        c_d.asel  = AS_ROW;
                        c_d.cnt   = CW'(T_RCD - 1);
                        open_set  = 1'b1;
                        set_row   = in_row;
                    end
                end
            end
            ST_PRE: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else if (c_q.to_ref) begin
                    c_d.st    = ST_RRAS;
                    c_d.ras_n = 1'b0;
                    c_d.asel  = AS_REF;
                    c_d.cnt   = CW'(T_RAS - 1);
                end else begin
                    c_d.st    = ST_ACT;
                    c_d.ras_n = 1'b0;
                    c_d.asel  = AS_ROW;
                    c_d.cnt   = CW'(T_RCD - 1);
                    open_set  = 1'b1;
                end
            end
            ST_ACT: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else begin
                    c_d.st    = ST_CAS;
                    c_d.cas_n = 1'b0;
                    c_d.we_n  = !c_q.we;
                    c_d.asel  = AS_COL;
                    c_d.cnt   = CW'(T_CL - 1);
                end
            end
            ST_CAS: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else begin
                    c_d.st    = ST_IDLE;
                    c_d.cas_n = 1'b1;
                    c_d.we_n  = 1'b1;
                    if (!c_q.we) begin
                        c_d.rsp_v = 1'b1;
                        c_d.rdata = dram_rdata;
                    end
                end
            end
            ST_RRAS: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else begin
                    c_d.st    = ST_RREC;
                    c_d.ras_n = 1'b1;
                    c_d.cnt   = CW'(T_RP - 1);
                    ref_done  = 1'b1;
                end
            end
            ST_RREC: begin
                if (c_q.cnt != '0) c_d.cnt = c_q.cnt - 1'b1;
                else               c_d.st  = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.st    <= ST_IDLE;
            c_q.asel  <= AS_ROW;
            c_q.ras_n <= 1'b1;
            c_q.cas_n <= 1'b1;
            c_q.we_n  <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign dram_ras_n = c_q.ras_n;
    assign dram_cas_n = c_q.cas_n;
    assign dram_we_n  = c_q.we_n;
    assign dram_wdata = c_q.wdata;
    assign rsp_valid  = c_q.rsp_v;
    assign rsp_rdata  = c_q.rdata;

    // Strobe-timing observers for the assertions below
    logic [CW-1:0] ras_hi_q, ras_lo_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_hi_q <= CW'(TMAX);
            ras_lo_q <= '0;
        end else begin
            ras_hi_q <= !dram_ras_n ? '0 : (ras_hi_q == CW'(TMAX) ? ras_hi_q : ras_hi_q + 1'b1);
            ras_lo_q <= dram_ras_n ? '0 : (ras_lo_q == CW'(TMAX) ? ras_lo_q : ras_lo_q + 1'b1);
        end
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n); // R10
    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> ras_hi_q >= CW'(T_RP)); // R10
    AST_RAS_TO_CAS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> ras_lo_q >= CW'(T_RCD)); // R10
    AST_READY_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11
endmodule

// File: tb/dram_page_ctrl_bench.sv
module dram_page_ctrl_bench;
    localparam int ROW_W   = 4;
    localparam int COL_W   = 4;
    localparam int DW      = 8;
    localparam int AW      = ROW_W + COL_W;
    localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int T_RP    = 2;
    localparam int T_RCD   = 3;
    localparam int T_CL    = 2;
    localparam int T_RAS   = 3;
    localparam int REF_CYC = 150;
    localparam int WIN     = 2 * T_RP + T_RCD + T_CL + T_RAS + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [MA_W-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n;
    logic [DW-1:0] dram_wdata, dram_rdata;

    always #2 clk = ~clk;

    dram_page_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_RP(T_RP), .T_RCD(T_RCD),
        .T_CL(T_CL), .T_RAS(T_RAS), .REF_CYC(REF_CYC)
    ) u_dram_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural DRAM array and bench-side shadow copy
    logic [DW-1:0] mem     [0:(1<<AW)-1];
    logic [DW-1:0] exp_mem [0:(1<<AW)-1];
    logic [ROW_W-1:0] m_row = '0;
    logic [ROW_W-1:0] cas_row = '0;
    logic [COL_W-1:0] cas_col = '0;
    bit   cur_we = 1'b0;
    bit   prev_ras = 1'b1, prev_cas = 1'b1, cas_seen = 1'b0;
    int   ras_hi = 1000, ras_lo = 0;
    int   cyc = 0, fall_cyc = 0, last_ref_fall = 0, ref_cnt = 0;
    logic [ROW_W-1:0] exp_ref_row = '0;

    assign dram_rdata = dram_cas_n ? '0 : mem[{m_row, dram_addr[COL_W-1:0]}];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !dram_ras_n) begin
                check(ras_hi >= T_RP, "R10", "row strobe high time", ras_hi, T_RP);
                m_row    = dram_addr[ROW_W-1:0];
                cas_seen = 1'b0;
                fall_cyc = cyc;
            end
            if (!dram_cas_n) begin
                if (dram_ras_n) check(1'b0, "R10", "column strobe without row", 1, 0);
                if (prev_cas) begin
                    check(ras_lo >= T_RCD, "R10", "row-to-column delay", ras_lo, T_RCD);
                    cas_row = m_row;
                    cas_col = dram_addr[COL_W-1:0];
                    check(dram_we_n == !cur_we, "R6", "write enable level", dram_we_n, !cur_we);
                end
                cas_seen = 1'b1;
                if (!dram_we_n) mem[{m_row, dram_addr[COL_W-1:0]}] = dram_wdata;
            end
            if (!prev_ras && dram_ras_n && !cas_seen) begin
                check(m_row == exp_ref_row, "R7", "refresh row", m_row, exp_ref_row);
                if (ref_cnt > 0) begin
                    check((fall_cyc - last_ref_fall <= REF_CYC + WIN) &&
                          (fall_cyc - last_ref_fall >= REF_CYC - WIN),
                          "R7", "refresh spacing", fall_cyc - last_ref_fall, REF_CYC);
                end
                last_ref_fall = fall_cyc;
                exp_ref_row   = exp_ref_row + 1'b1;
                ref_cnt++;
            end
            if (dram_ras_n) begin ras_hi++; ras_lo = 0; end
            else            begin ras_lo++; ras_hi = 0; end
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
        end
    end

    bit open_v = 1'b0;
    logic [ROW_W-1:0] open_row = '0;
    int ref_at_acc = 0;

    function automatic int exp_latency(int kind);
        if (kind == 0) return T_RCD + T_CL + 1;
        if (kind == 1) return T_CL + 1;
        return T_RP + T_RCD + T_CL + 1;
    endfunction

    task automatic access(bit we, logic [AW-1:0] a, logic [DW-1:0] wd);
        int kind, lat, ref_before;
        string rq;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        cur_we = we;
        if (ref_cnt != ref_at_acc && open_v) begin kind = 0; rq = "R9"; end
        else if (!open_v) begin kind = 0; rq = "R3"; end
        else if (open_row == a[AW-1:COL_W]) begin kind = 1; rq = "R4"; end
        else begin kind = 2; rq = "R5"; end
        ref_before = ref_cnt;
        ref_at_acc = ref_cnt;
        open_v = 1'b1;
        open_row = a[AW-1:COL_W];
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (we) begin
            exp_mem[a] = wd;
            while (!req_ready && lat < 100) begin @(negedge clk); lat++; end
        end else begin
            while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
            check(lat == exp_latency(kind), rq, "read latency", lat, exp_latency(kind));
            check(rsp_rdata == exp_mem[a], "R6", "read data", rsp_rdata, exp_mem[a]);
            check(ref_cnt == ref_before, "R8", "refresh inside read", ref_cnt, ref_before);
            @(negedge clk);
            check(!rsp_valid, "R11", "response pulse width", rsp_valid, 0);
        end
        check({cas_row, cas_col} == a, "R2", "address split", {cas_row, cas_col}, a);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin
            mem[i] = '0;
            exp_mem[i] = '0;
        end
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        check(dram_ras_n && dram_cas_n, "R1", "strobes idle in reset", {dram_ras_n, dram_cas_n}, 3);
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "no response in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dram_ras_n && req_ready, "R1", "idle after reset", {dram_ras_n, req_ready}, 3);

        access(1'b1, 8'h35, 8'hA5);   // closed bank write
        access(1'b0, 8'h35, 8'h00);   // hit read
        access(1'b0, 8'h3A, 8'h00);   // hit read, other column
        access(1'b1, 8'h72, 8'h5C);   // miss write
        access(1'b0, 8'h35, 8'h00);   // miss read
        access(1'b0, 8'h72, 8'h00);   // miss read
        access(1'b1, 8'h7F, 8'hFF);   // hit write, top column
        access(1'b0, 8'h7F, 8'h00);
        repeat (REF_CYC + 20) @(negedge clk);
        check(ref_cnt >= 1, "R7", "refresh issued while idle", ref_cnt, 1);
        access(1'b0, 8'h72, 8'h00);   // first access after refresh

        for (int n = 0; n < 700; n++) begin
            logic [ROW_W-1:0] r;
            logic [COL_W-1:0] c;
            r = ($urandom_range(0, 9) < 6) ? open_row : ROW_W'($urandom);
            c = COL_W'($urandom);
            access(($urandom_range(0, 1) == 1), {r, c}, DW'($urandom));
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        check(ref_cnt > (1 << ROW_W), "R7", "refresh row wrap reached", ref_cnt, (1 << ROW_W) + 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule